// File: doc/BRIEF.md
# Reduced Boundary-Scan Test Port Controller

This block is a serial test port controller clocked by its own test clock. A single mode input steers it through the usual sixteen-state test port graph. A 3-bit instruction decides which data register sits between the serial input and the serial output. Three registers can be selected: a 32-bit identification register, a 1-bit bypass register, and a boundary chain whose length is a parameter. The boundary chain is modelled as a shift register that takes a parallel snapshot of an input vector standing for the I/O ring.

The instruction set is deliberately reduced. The two boundary instructions only take a snapshot of the ring and raise a flag that asks the core to float its outputs. Nothing is ever preloaded into the ring or driven from it, so the controller can never steer the core's address, data or control lines. Every code that is not one of the three defined instructions selects bypass. Holding the mode input high for five test clock edges brings the port back to its reset state and has no effect on the core's normal operation.

The serial output is updated on the falling test clock edge. A companion enable shows when the output is meant to be driven.

Top module: `scan_tap_ctrl`

## Requirements
- R1: A low `rst_n` at a rising `tck` edge, or five consecutive rising edges with `tms` high from any state, puts the controller in its reset state. Leaving that state makes the identification instruction (code 001) current and drops `core_hiz`.
- R2: State changes follow the standard sixteen-state test port graph, including the pause and exit2 path, which resumes shifting without losing data already shifted.
- R3: Capture of the instruction stage loads the pattern 001, which then shifts out on `tdo` least significant bit first. Bits shifted in from `tdi` become the current instruction only at the instruction update state.
- R4: With code 001 current, data capture loads the 32-bit `ID_VALUE`, which shifts out least significant bit first, and `core_hiz` stays low.
- R5: With code 000 current, data capture loads `io_ring` into the boundary chain, which shifts out bit 0 first, and `core_hiz` is high.
- R6: With code 010 current, the boundary chain is selected and captures `io_ring` in the same way as R5, and `core_hiz` is high.
- R7: Codes 011, 100, 101, 110 and 111 select the 1-bit bypass register. It captures 0, so a data scan returns a 0 followed by the `tdi` bits delayed by one clock, and `core_hiz` stays low.
- R8: `tdo` changes only on a falling `tck` edge. `tdo_oe` is high only in the falling-edge intervals that follow entry into, or a stay in, an instruction-shift or data-shift state.
- R9: The current instruction, and with it `core_hiz`, stays unchanged through data scans and through every state other than instruction update and reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled on `tck` |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| io_ring | input | BND_LEN | Parallel snapshot source for the boundary chain |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | High while `tdo` is meant to be driven |
| core_hiz | output | 1 | Asks the core to float its outputs |

## Verification
The assertions assume that `rst_n` is held low over at least two rising `tck` edges before it is released. They also assume that `tms`, `tdi` and `io_ring` are stable around each rising edge, so that `$past` samples of them are meaningful. The bench meets both conditions: it holds reset for four cycles and changes all inputs one nanosecond after each falling edge. It also samples `tdo` and `tdo_oe` at that same moment, so what it observes is always a value launched by a falling edge.

// File: rtl/scan_tap_pkg.sv
// Shared types for the reduced test port controller: controller states,
// instruction codes and the data register selector.
package scan_tap_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_RESET  = 4'd0,
        ST_IDLE   = 4'd1,
        ST_SEL_DR = 4'd2,
        ST_CAP_DR = 4'd3,
        ST_SHF_DR = 4'd4,
        ST_EX1_DR = 4'd5,
        ST_PAU_DR = 4'd6,
        ST_EX2_DR = 4'd7,
        ST_UPD_DR = 4'd8,
        ST_SEL_IR = 4'd9,
        ST_CAP_IR = 4'd10,
        ST_SHF_IR = 4'd11,
        ST_EX1_IR = 4'd12,
        ST_PAU_IR = 4'd13,
        ST_EX2_IR = 4'd14,
        ST_UPD_IR = 4'd15
    } tap_state_t;

    localparam logic [IR_W-1:0] OP_BND_EXT = 3'b000;
    localparam logic [IR_W-1:0] OP_IDENT   = 3'b001;
    localparam logic [IR_W-1:0] OP_BND_SMP = 3'b010;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [1:0] {
        SEL_BND = 2'd0,
        SEL_ID  = 2'd1,
        SEL_BYP = 2'd2
    } dr_sel_t;

    // Map an instruction code to the data register it places in the path.
    function automatic dr_sel_t decode_sel(input logic [IR_W-1:0] op);
        case (op)
            OP_BND_EXT, OP_BND_SMP: decode_sel = SEL_BND;
            OP_IDENT:               decode_sel = SEL_ID;
            default:                decode_sel = SEL_BYP;
        endcase
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
// Sixteen-state test port controller.
// Assumes tms is stable around the rising tck edge; rst_n is synchronous.
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t nxt;

    // Next-state selection from the current state and tms.
    always_comb begin
        case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

    // Checker counter: consecutive rising edges that saw tms high, saturating at 5.
    logic [2:0] ones_cnt;
    always_ff @(posedge tck) begin
        if (!rst_n)              ones_cnt <= '0;
        else if (!tms)           ones_cnt <= '0;
        else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
    end

    a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (!rst_n)
        (ones_cnt == 3'd5) |-> (state == ST_RESET));

    a_r2_capture_entry: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_DR) |-> ($past(state) == ST_SEL_DR));

endmodule

// File: rtl/scan_tap_ir.sv
// Instruction register: a shift stage and the current instruction.
// Capture loads a fixed pattern; the current instruction changes only at
// update or in the reset state.
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_t      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_cur,
    output logic            ir_lsb
);

    logic [IR_W-1:0] ir_sr;

    // Shift stage: capture the fixed pattern or shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n)                  ir_sr <= IR_CAPTURE;
        else if (state == ST_CAP_IR) ir_sr <= IR_CAPTURE;
        else if (state == ST_SHF_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Current instruction: identification after reset, else loaded at update.
    always_ff @(posedge tck) begin
        if (!rst_n || state == ST_RESET) ir_cur <= OP_IDENT;
        else if (state == ST_UPD_IR)     ir_cur <= ir_sr;
    end

    assign ir_lsb = ir_sr[0];

    a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE));

    a_r9_instr_hold: assert property (@(posedge tck) disable iff (!rst_n)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir_cur));

endmodule

// File: rtl/scan_tap_dr.sv
// Data registers: identification, bypass and a boundary chain of BND_LEN
// cells. Only the selected register captures and shifts.
// Assumes io_ring is stable around the rising tck edge.
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int          BND_LEN  = 16,
    parameter logic [31:0] ID_VALUE = 32'h4A7D_21E3
)(
    input  logic               tck,
    input  logic               rst_n,
    input  tap_state_t         state,
    input  dr_sel_t            sel,
    input  logic               tdi,
    input  logic [BND_LEN-1:0] io_ring,
    output logic               dr_lsb
);

    localparam int ID_W = 32;

    logic [ID_W-1:0]    id_sr;
    logic               byp;
    logic [BND_LEN-1:0] bnd;
    logic [BND_LEN:0]   bnd_chain;

    logic cap, shf;
    assign cap = (state == ST_CAP_DR);
    assign shf = (state == ST_SHF_DR);

    // Identification register: load the fixed code on capture, shift when selected.
    always_ff @(posedge tck) begin
        if (!rst_n)                    id_sr <= ID_VALUE;
        else if (sel == SEL_ID && cap) id_sr <= ID_VALUE;
        else if (sel == SEL_ID && shf) id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

    // Bypass cell: captures zero, passes tdi through one stage.
    always_ff @(posedge tck) begin
        if (!rst_n)                     byp <= 1'b0;
        else if (sel == SEL_BYP && cap) byp <= 1'b0;
        else if (sel == SEL_BYP && shf) byp <= tdi;
    end

    assign bnd_chain = {tdi, bnd};

    // One boundary cell per ring bit: snapshot on capture, take upper neighbour on shift.
    for (genvar i = 0; i < BND_LEN; i++) begin : g_cell
        always_ff @(posedge tck) begin
            if (!rst_n)                     bnd[i] <= 1'b0;
            else if (sel == SEL_BND && cap) bnd[i] <= io_ring[i];
            else if (sel == SEL_BND && shf) bnd[i] <= bnd_chain[i+1];
        end
    end

    // Serial output of the selected register.
    always_comb begin
        case (sel)
            SEL_ID:  dr_lsb = id_sr[0];
            SEL_BND: dr_lsb = bnd[0];
            default: dr_lsb = byp;
        endcase
    end

    a_r4_id_load: assert property (@(posedge tck) disable iff (!rst_n)
        (cap && sel == SEL_ID) |=> (id_sr == ID_VALUE));

    a_r5_ring_snapshot: assert property (@(posedge tck) disable iff (!rst_n)
        (cap && sel == SEL_BND) |=> (bnd == $past(io_ring)));

    a_r7_bypass_zero: assert property (@(posedge tck) disable iff (!rst_n)
        (cap && sel == SEL_BYP) |=> (byp == 1'b0));

endmodule

// File: rtl/scan_tap_ctrl.sv
// Top of the reduced test port controller. It ties the state machine,
// the instruction register and the data registers together and launches
// tdo and its enable on the falling tck edge.
// Assumes rst_n is synchronous to tck.
module scan_tap_ctrl
    import scan_tap_pkg::*;
#(
    parameter int          BND_LEN  = 16,
    parameter logic [31:0] ID_VALUE = 32'h4A7D_21E3
)(
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BND_LEN-1:0] io_ring,
    output logic               tdo,
    output logic               tdo_oe,
    output logic               core_hiz
);

    tap_state_t      state;
    logic [IR_W-1:0] ir_cur;
    logic            ir_lsb;
    logic            dr_lsb;
    dr_sel_t         sel;
    logic            tdo_q, oe_q;

    scan_tap_fsm u_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (state)
    );

    scan_tap_ir u_ir (
        .tck    (tck),
        .rst_n  (rst_n),
        .state  (state),
        .tdi    (tdi),
        .ir_cur (ir_cur),
        .ir_lsb (ir_lsb)
    );

    assign sel = decode_sel(ir_cur);

    scan_tap_dr #(
        .BND_LEN  (BND_LEN),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck     (tck),
        .rst_n   (rst_n),
        .state   (state),
        .sel     (sel),
        .tdi     (tdi),
        .io_ring (io_ring),
        .dr_lsb  (dr_lsb)
    );

    // Falling-edge output stage: drive only in the shift states.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            oe_q <= (state == ST_SHF_IR) || (state == ST_SHF_DR);
            if (state == ST_SHF_IR)      tdo_q <= ir_lsb;
            else if (state == ST_SHF_DR) tdo_q <= dr_lsb;
        end
    end

    assign tdo      = tdo_q;
    assign tdo_oe   = oe_q;
    assign core_hiz = (ir_cur == OP_BND_EXT) || (ir_cur == OP_BND_SMP);

    a_r6_hiz_boundary: assert property (@(posedge tck) disable iff (!rst_n)
        core_hiz |-> (sel == SEL_BND));

    a_r8_tdo_launch: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe |-> ($past(state) == ST_SHF_IR || $past(state) == ST_SHF_DR ||
                    $past(state) == ST_CAP_IR || $past(state) == ST_CAP_DR ||
                    $past(state) == ST_EX2_IR || $past(state) == ST_EX2_DR));

endmodule

// File: tb/scan_tap_ctrl_tb.sv
`timescale 1ns/1ps
module scan_tap_ctrl_tb;

    localparam int          BND   = 16;
    localparam logic [31:0] TB_ID = 32'h4A7D_21E3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic [BND-1:0] io_ring = '0;
    logic tdo, tdo_oe, core_hiz;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit edge_bad = 1'b0;

    always #2 clk = ~clk;

    scan_tap_ctrl #(.BND_LEN(BND), .ID_VALUE(TB_ID)) u_dut (
        .tck(clk), .rst_n(rst_n), .tms(tms), .tdi(tdi), .io_ring(io_ring),
        .tdo(tdo), .tdo_oe(tdo_oe), .core_hiz(core_hiz)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One test clock: sample outputs after the falling edge, drive inputs,
    // then confirm tdo did not move at the rising edge.
    task automatic step(input logic t, input logic d, output logic o, output logic oe);
        @(negedge clk);
        #1;
        o = tdo;
        oe = tdo_oe;
        tms = t;
        tdi = d;
        @(posedge clk);
        #0.5;
        if (tdo !== o) edge_bad = 1'b1;
    endtask

    // Full scan from Run-Test/Idle back to Run-Test/Idle.
    task automatic scan(input bit is_ir, input int n, input logic [63:0] din,
                        output logic [63:0] dout, output bit oe_ok);
        logic o, oe;
        dout = '0;
        oe_ok = 1'b1;
        step(1, 0, o, oe);
        if (is_ir) step(1, 0, o, oe);
        step(0, 0, o, oe);
        step(0, 0, o, oe);
        if (oe) oe_ok = 1'b0;
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o, oe);
            dout[i] = o;
            if (!oe) oe_ok = 1'b0;
        end
        step(1, 0, o, oe);
        if (oe) oe_ok = 1'b0;
        step(0, 0, o, oe);
    endtask

    task automatic load_ir(input logic [2:0] code, output logic [63:0] dout);
        bit ok;
        scan(1, 3, {61'd0, code}, dout, ok);
    endtask

    task automatic t_reset;
        logic [63:0] d;
        bit ok;
        check("R1 reset tdo_oe", tdo_oe, 0);
        check("R1 reset core_hiz", core_hiz, 0);
        scan(0, 32, 64'h0, d, ok);
        check("R4 identification after reset", d[31:0], TB_ID);
        check("R8 oe only while shifting", ok, 1);
        check("R4 hiz low", core_hiz, 0);
    endtask

    task automatic t_sample;
        logic [63:0] d;
        bit ok;
        io_ring = 16'hA5C3;
        load_ir(3'b010, d);
        check("R3 capture pattern", d[2:0], 3'b001);
        check("R6 hiz high", core_hiz, 1);
        scan(0, BND, 64'hFFFF, d, ok);
        check("R6 boundary snapshot", d[BND-1:0], 16'hA5C3);
        check("R9 hiz kept after data scan", core_hiz, 1);
        scan(0, BND, 64'h0, d, ok);
        check("R6 fresh snapshot", d[BND-1:0], 16'hA5C3);
    endtask

    task automatic t_extest;
        logic [63:0] d;
        bit ok;
        io_ring = 16'h3C96;
        load_ir(3'b000, d);
        check("R5 hiz high", core_hiz, 1);
        scan(0, BND, 64'h0, d, ok);
        check("R5 boundary snapshot", d[BND-1:0], 16'h3C96);
    endtask

    task automatic t_bypass;
        logic [63:0] d;
        bit ok;
        for (int c = 3; c < 8; c++) begin
            load_ir(c[2:0], d);
            check("R7 hiz low for bypass code", core_hiz, 0);
            scan(0, 8, 64'hB6, d, ok);
            check("R7 one-stage bypass", d[7:0], 8'h6C);
        end
    endtask

    task automatic t_pause;
        logic [63:0] d;
        logic o, oe;
        load_ir(3'b001, d);
        d = '0;
        step(1, 0, o, oe);
        step(0, 0, o, oe);
        step(0, 0, o, oe);
        for (int i = 0; i < 16; i++) begin
            step(i == 15, 0, o, oe);
            d[i] = o;
        end
        step(0, 0, o, oe);
        check("R8 oe low in exit1", oe, 0);
        step(0, 0, o, oe);
        check("R8 oe low in pause", oe, 0);
        step(1, 0, o, oe);
        step(0, 0, o, oe);
        for (int i = 16; i < 32; i++) begin
            step(i == 31, 0, o, oe);
            d[i] = o;
        end
        step(1, 0, o, oe);
        step(0, 0, o, oe);
        check("R2 pause path keeps data", d[31:0], TB_ID);
    endtask

    task automatic t_tms_reset;
        logic [63:0] d;
        logic o, oe;
        bit ok;
        load_ir(3'b000, d);
        check("R9 hiz before tms reset", core_hiz, 1);
        step(1, 0, o, oe);
        step(0, 0, o, oe);
        step(0, 0, o, oe);
        for (int i = 0; i < 3; i++) step(0, 1, o, oe);
        for (int i = 0; i < 5; i++) step(1, 0, o, oe);
        step(0, 0, o, oe);
        check("R1 tms reset drops hiz", core_hiz, 0);
        scan(0, 32, 64'h0, d, ok);
        check("R1 identification after tms reset", d[31:0], TB_ID);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        begin
            logic o, oe;
            step(0, 0, o, oe);
        end
        t_reset();
        t_sample();
        t_extest();
        t_bypass();
        t_pause();
        t_tms_reset();
        check("R8 tdo stable at rising edge", edge_bad, 0);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule